// File: doc/BRIEF.md
# Fractional clock rate controller

This block produces a per-cycle enable that qualifies a parent clock so that a chosen fraction of its cycles pass. The fraction is set by a 5-bit code. The number of kept cycles in every 32-cycle span is 32 minus the code. Code 0 keeps every cycle, and code 31 keeps one cycle in 32. The kept cycles are spread as evenly as possible over the span, so the logic running on the qualified clock sees a steady effective rate with no bursts.

Software uses two 32-bit registers. It writes the code into a control register, then sets a request bit in a trigger register. The hardware takes the requested code and applies it at the next 32-cycle frame boundary, then clears the request bit. Software treats a set request bit as busy and polls it until it reads zero.

Top module: `frac_clk_ctrl`

## Requirements
- R1: In any 32 consecutive cycles during which the applied code does not change, `clk_en_o` is high in exactly 32 minus the code cycles. The code is bits 12:8 of the control register at address 0x0E0.
- R2: While the applied code does not change, the gaps between consecutive cycles with `clk_en_o` high differ from one another by at most one cycle.
- R3: After reset, the control register reads 0, the trigger register reads 0, and `clk_en_o` is high in every cycle.
- R4: All 32 bits of the control register can be written and read back unchanged.
- R5: The trigger register at address 0x004 reads bit 31 as the request bit, and all its other bits read 0. Writing 1 to bit 31 sets the request bit. Writing 0 to bit 31 does not clear it.
- R6: Writing the control register without setting the request bit does not change the rate on `clk_en_o`.
- R7: A requested code takes effect only at the first cycle of a 32-cycle frame. The request bit clears one cycle after that, no more than 34 cycles after it was set.
- R8: While the request bit is set, writes to either register do not alter the pending request. The code applied on completion is the code that was in the control register when the request bit was set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Parent clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 12 | Register address |
| reg_we_i | input | 1 | Register write strobe |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational from the address) |
| clk_en_o | output | 1 | Enable that qualifies the parent clock |

## Verification
The rate is tested with the extreme codes 0 and 31, the mid code 16, and the codes 27 and 5. The mid code gives an exact period. The codes 27 and 5 leave 5 and 27 kept cycles in a frame, which divide 32 unevenly. So a counting error, an inverted code or bunched enables would each show up. Each rate is checked for both the count per 32-cycle window and the spread of the gaps between enables. A write that is not followed by a request, a write that clears bit 31 of the trigger register, and a control write made while busy are each followed by a rate measurement. This separates a design that applies the code only when requested from one that applies it on every write. A second request after the busy case confirms that the later write was kept in the control register for the next request.

// File: rtl/frac_clk_pkg.sv
package frac_clk_pkg;
  localparam int unsigned REG_W = 32;
  typedef logic [REG_W-1:0] reg_word_t;
endpackage

// File: rtl/frac_regs.sv
module frac_regs
  import frac_clk_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned CODE_W    = 5,
  parameter int unsigned CODE_LSB  = 8,
  parameter int unsigned KICK_BIT  = 31,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h0E0,
  parameter logic [ADDR_W-1:0] TRIG_ADDR = 'h004
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  reg_word_t         wdata_i,
  output reg_word_t         rdata_o,
  input  logic              clr_i,
  output logic              kick_o,
  output logic [CODE_W-1:0] pending_o
);
  reg_word_t         ctrl_q;
  logic              kick_q;
  logic [CODE_W-1:0] pending_q;
  logic              ctrl_wr, kick_set;

  assign ctrl_wr  = we_i && (addr_i == CTRL_ADDR);
  // a request while busy is dropped
  assign kick_set = we_i && (addr_i == TRIG_ADDR) && wdata_i[KICK_BIT] && !kick_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (ctrl_wr) begin
      ctrl_q <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      kick_q    <= 1'b0;
      pending_q <= '0;
    end else if (kick_set) begin
      kick_q    <= 1'b1;
      pending_q <= ctrl_q[CODE_LSB +: CODE_W];
    end else if (clr_i) begin
      kick_q    <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == CTRL_ADDR) begin
      rdata_o = ctrl_q;
    end else if (addr_i == TRIG_ADDR) begin
      rdata_o[KICK_BIT] = kick_q;
    end
  end

  assign kick_o    = kick_q;
  assign pending_o = pending_q;
endmodule

// File: rtl/frac_frame.sv
module frac_frame #(
  parameter int unsigned CODE_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              kick_i,
  input  logic [CODE_W-1:0] pending_i,
  output logic [CODE_W-1:0] active_o,
  output logic [CODE_W-1:0] frame_cnt_o,
  output logic              clr_o
);
  logic [CODE_W-1:0] cnt_q, active_q;
  logic              done_q, last, load;

  assign last = &cnt_q;
  assign load = kick_i && last && !done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      active_q <= '0;
      done_q   <= 1'b0;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
      done_q <= load;
      if (load) active_q <= pending_i;
    end
  end

  assign active_o    = active_q;
  assign frame_cnt_o = cnt_q;
  assign clr_o       = done_q;
endmodule

// File: rtl/frac_accum.sv
module frac_accum #(
  parameter int unsigned CODE_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CODE_W-1:0] code_i,
  output logic              en_o
);
  localparam logic [CODE_W:0] FRAME = (CODE_W+1)'(1) << CODE_W;

  logic [CODE_W-1:0] acc_q;
  logic [CODE_W:0]   mult, sum;

  assign mult = FRAME - {1'b0, code_i};
  assign sum  = {1'b0, acc_q} + mult;
  assign en_o = sum[CODE_W];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= '0;
    else         acc_q <= sum[CODE_W-1:0];
  end
endmodule

// File: rtl/frac_clk_ctrl.sv
module frac_clk_ctrl
  import frac_clk_pkg::*;
#(
  parameter int unsigned ADDR_W   = 12,
  parameter int unsigned CODE_W   = 5,
  parameter int unsigned CODE_LSB = 8,
  parameter int unsigned KICK_BIT = 31,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h0E0,
  parameter logic [ADDR_W-1:0] TRIG_ADDR = 'h004
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic              reg_we_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  output logic              clk_en_o
);
  logic              kick, clr;
  logic [CODE_W-1:0] pending_code, active_code, frame_cnt;

  frac_regs #(
    .ADDR_W(ADDR_W), .CODE_W(CODE_W), .CODE_LSB(CODE_LSB),
    .KICK_BIT(KICK_BIT), .CTRL_ADDR(CTRL_ADDR), .TRIG_ADDR(TRIG_ADDR)
  ) u_regs (
    .clk_i, .rst_ni,
    .addr_i(reg_addr_i), .we_i(reg_we_i), .wdata_i(reg_wdata_i),
    .rdata_o(reg_rdata_o), .clr_i(clr), .kick_o(kick), .pending_o(pending_code)
  );

  frac_frame #(.CODE_W(CODE_W)) u_frame (
    .clk_i, .rst_ni,
    .kick_i(kick), .pending_i(pending_code), .active_o(active_code),
    .frame_cnt_o(frame_cnt), .clr_o(clr)
  );

  frac_accum #(.CODE_W(CODE_W)) u_accum (
    .clk_i, .rst_ni, .code_i(active_code), .en_o(clk_en_o)
  );
endmodule

// File: rtl/frac_clk_ctrl_chk.sv
module frac_clk_ctrl_chk #(
  parameter int unsigned CODE_W = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              clk_en_i,
  input logic              kick_i,
  input logic [CODE_W-1:0] pending_i,
  input logic [CODE_W-1:0] active_i,
  input logic [CODE_W-1:0] frame_cnt_i
);
  localparam logic [CODE_W:0] FRAME = (CODE_W+1)'(1) << CODE_W;
  logic [CODE_W:0] en_cnt;
  logic            last;

  assign last = &frame_cnt_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   en_cnt <= '0;
    else if (last) en_cnt <= '0;
    else           en_cnt <= en_cnt + (CODE_W+1)'(clk_en_i);
  end

  p_frame_count_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last |-> (en_cnt + (CODE_W+1)'(clk_en_i)) == (FRAME - {1'b0, active_i}));

  p_full_rate_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (active_i == '0) |-> clk_en_i);

  p_code_mid_frame_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !last |=> $stable(active_i));

  p_kick_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(kick_i) |-> frame_cnt_i == CODE_W'(1));

  p_busy_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    kick_i |=> $stable(pending_i));
endmodule

bind frac_clk_ctrl frac_clk_ctrl_chk #(.CODE_W(CODE_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .clk_en_i(clk_en_o), .kick_i(kick),
  .pending_i(pending_code), .active_i(active_code), .frame_cnt_i(frame_cnt)
);

// File: tb/frac_clk_ctrl_tb.sv
module frac_clk_ctrl_tb;
  localparam logic [11:0] CTRL = 12'h0E0;
  localparam logic [11:0] TRIG = 12'h004;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [11:0] addr = '0;
  logic        we = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        en;
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #5 clk = ~clk;

  frac_clk_ctrl u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .reg_addr_i(addr), .reg_we_i(we),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .clk_en_o(en)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1'b1;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic count_en(input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk); #2; c += int'(en);
    end
  endtask

  task automatic check_rate(input int code, input string req);
    int c;
    count_en(32, c);
    check(c == 32 - code, req, c, 32 - code);
  endtask

  // R2: gap spread over 96 cycles
  task automatic check_spread(input string req);
    int last_i, gmin, gmax;
    last_i = -1; gmin = 1000; gmax = 0;
    for (int i = 0; i < 96; i++) begin
      @(negedge clk); #2;
      if (en) begin
        if (last_i >= 0) begin
          if (i - last_i < gmin) gmin = i - last_i;
          if (i - last_i > gmax) gmax = i - last_i;
        end
        last_i = i;
      end
    end
    check(gmax - gmin <= 1, req, gmax - gmin, 1);
  endtask

  task automatic wait_kick(input string req);
    logic [31:0] d;
    int polls;
    polls = 0;
    do begin
      rd(TRIG, d);
      polls++;
    end while (d[31] && polls < 1000);
    if (d[31]) check(1'b0, "R7 timeout", polls, 1000);
    else check(polls <= 34, req, polls, 34);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(CTRL, d); check(d == 32'h0, "R3 ctrl", d, 0);
    rd(TRIG, d); check(d == 32'h0, "R3 trig", d, 0);
    check_rate(0, "R3 full rate");
  endtask

  task automatic t_no_kick;
    logic [31:0] d;
    wr(CTRL, 32'hA5A5_1F5A);
    rd(CTRL, d); check(d == 32'hA5A5_1F5A, "R4 readback", d, 32'hA5A5_1F5A);
    repeat (40) @(negedge clk);
    check_rate(0, "R6 no kick");
    wr(TRIG, 32'h7FFF_FFFF);
    rd(TRIG, d); check(d == 32'h0, "R5 bit31 clear write", d, 0);
    check_rate(0, "R6 after zero trigger");
  endtask

  task automatic t_apply(input int code);
    logic [31:0] d;
    wr(CTRL, 32'h1234_00C3 | (32'(code) << 8));
    wr(TRIG, 32'h8000_0000);
    rd(TRIG, d); check(d == 32'h8000_0000, "R5 kick set", d, 32'h8000_0000);
    wait_kick("R7 clear latency");
    check_rate(code, "R1 rate");
    check_spread("R2 spread");
  endtask

  task automatic t_busy;
    logic [31:0] d;
    wr(CTRL, 32'(20) << 8);
    wr(TRIG, 32'h8000_0000);
    wr(CTRL, 32'(3) << 8);
    wr(TRIG, 32'h8000_0000);
    wr(TRIG, 32'h0);
    rd(TRIG, d); check(d == 32'h8000_0000, "R5 zero write keeps kick", d, 32'h8000_0000);
    wait_kick("R8 clear latency");
    check_rate(20, "R8 first code applied");
    rd(CTRL, d); check(d == 32'h0000_0300, "R8 later write kept", d, 32'h300);
    wr(TRIG, 32'h8000_0000);
    wait_kick("R8 second clear");
    check_rate(3, "R8 second code applied");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_no_kick();
    t_apply(31);
    t_apply(16);
    t_apply(27);
    t_apply(5);
    t_apply(0);
    t_busy();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog", 0, 1);
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule